// File: doc/BRIEF.md
# Destination Address Receive Filter

This block decides whether a received Ethernet frame should be kept, judging only by its destination address. The six address bytes arrive one per accepted cycle at the start of the frame. The first byte is flagged as the frame start, and idle cycles may fall between bytes. While the bytes stream in, the block runs a CRC-32 over them and collects them into an address register. One cycle after the sixth byte it raises a one-cycle decision strobe, together with an accept flag.

The decision combines several inputs:
- a promiscuous override;
- a master address-filter enable;
- separate accept enables for broadcast and multicast traffic;
- an enable for the unicast station-address comparison;
- a 64-bin multicast hash table, supplied as two 32-bit words.

Multicast frames are looked up in the table through six bits taken from the address CRC. The surrounding receiver uses the strobe to keep or drop the frame it is buffering. Software computes the table contents outside this block.

Top module: `rxaf_filter`

## Requirements
- R1: A byte presented with `da_valid` and `da_first` high is destination byte 0. The next five bytes presented with `da_valid` high and `da_first` low are bytes 1 to 5, in order. Cycles with `da_valid` low between bytes are skipped.
- R2: `dec_valid` is high for exactly one cycle: the cycle after the clock edge that takes byte 5. `dec_accept` is low whenever `dec_valid` is low.
- R3: A new `da_first` in the middle of an address restarts collection from byte 0. Bytes with `da_first` low that arrive while no address is being collected are ignored and produce no decision.
- R4: When `cfg_promisc` is 1, every frame is accepted.
- R5: When `cfg_promisc` is 0 and `cfg_addr_filter` is 0, every frame is accepted.
- R6: With filtering active, an all-ones destination is accepted exactly when `cfg_bcast_accept` is 1.
- R7: With filtering active, a non-broadcast destination whose byte 0 has bit 0 set is a multicast address. With `cfg_mcast_accept` and `cfg_hash_enable` both 1, such a frame is accepted exactly when its table bin is set. The bin index is CRC bits 31:26. The CRC is computed as follows:
  - polynomial 0x04C11DB7, shifting toward the MSB;
  - register starts at all ones;
  - bytes taken in order 0 to 5, each least-significant bit first;
  - no final inversion.

  Bins 0 to 31 are `hash_tbl_lo` bits 0 to 31, and bins 32 to 63 are `hash_tbl_hi` bits 0 to 31.
- R8: A multicast frame is rejected when `cfg_mcast_accept` is 0. When `cfg_mcast_accept` is 1 and `cfg_hash_enable` is 0, it is accepted whatever the table holds.
- R9: With filtering active, a unicast frame is accepted exactly when `cfg_ucast_check` is 1 and the destination equals the station address. Bytes 0, 1 and 2 of the station address are `station_hi` bits 23:16, 15:8 and 7:0. Bytes 3, 4 and 5 are the same fields of `station_lo`.
- R10: After reset, `dec_valid` and `dec_accept` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| da_valid | input | 1 | An address byte is present |
| da_first | input | 1 | The present byte is destination byte 0 |
| da_byte | input | 8 | Destination address byte |
| cfg_promisc | input | 1 | Accept all frames |
| cfg_addr_filter | input | 1 | Enable address filtering |
| cfg_ucast_check | input | 1 | Accept unicast frames that match the station address |
| cfg_mcast_accept | input | 1 | Accept multicast frames |
| cfg_bcast_accept | input | 1 | Accept broadcast frames |
| cfg_hash_enable | input | 1 | Pass multicast frames through the hash table |
| station_hi | input | 24 | Station address bytes 0 to 2 |
| station_lo | input | 24 | Station address bytes 3 to 5 |
| hash_tbl_lo | input | 32 | Hash bins 0 to 31 |
| hash_tbl_hi | input | 32 | Hash bins 32 to 63 |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted, qualified by dec_valid |

## Verification
The assertions assume that the configuration and station inputs do not change during the decision cycle, since the decision reads them live in that cycle. They also assume that `da_valid` is never X after reset. The bench sets each configuration before the frame starts and changes it only after the strobe has dropped. It drives bytes only on falling edges, with `da_valid` always defined, so the assumptions hold throughout.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned ADDR_W     = 8 * ADDR_BYTES;
  localparam int unsigned CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam int unsigned HASH_W     = 6;
  localparam int unsigned TBL_WORD_W = 32;

  typedef struct packed {
    logic promisc;
    logic addr_filter;
    logic ucast_check;
    logic mcast_accept;
    logic bcast_accept;
    logic hash_enable;
  } rxaf_cfg_t;

  typedef enum logic [1:0] {
    CLS_UNICAST   = 2'd0,
    CLS_MULTICAST = 2'd1,
    CLS_BROADCAST = 2'd2
  } rxaf_class_e;

  // One byte through the MSB-shifting CRC, data bits taken LSB first.
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] crc_in,
                                                     input logic [7:0] data);
    logic [CRC_W-1:0] c;
    logic fb;
    c = crc_in;
    for (int k = 0; k < 8; k++) begin
      fb = c[CRC_W-1] ^ data[k];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/rxaf_capture.sv
module rxaf_capture
  import rxaf_pkg::*;
#(
  parameter int unsigned NBYTES = ADDR_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_first,
  input  logic [7:0]            in_byte,
  output logic                  byte_take,
  output logic                  byte_restart,
  output logic [8*NBYTES-1:0]   addr_flat,
  output logic                  done
);

  localparam int unsigned CNT_W = $clog2(NBYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NBYTES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             active_q, active_d;
  logic             done_q, done_d;
  logic             last_byte;
  logic [CNT_W-1:0] slot;

  assign byte_restart = in_valid & in_first;
  assign byte_take    = in_valid & (in_first | active_q);
  assign last_byte    = in_valid & ~in_first & active_q & (cnt_q == LAST_IDX);
  assign slot         = in_first ? '0 : cnt_q;

  always_comb begin
    cnt_d    = cnt_q;
    active_d = active_q;
    done_d   = last_byte;
    if (byte_restart) begin
      cnt_d    = CNT_W'(1);
      active_d = 1'b1;
    end else if (in_valid && active_q) begin
      if (last_byte) begin
        cnt_d    = '0;
        active_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
      done_q   <= done_d;
    end
  end

  // One storage byte per address position, byte 0 in the top bits.
  for (genvar i = 0; i < NBYTES; i++) begin : g_slot
    logic [7:0] byte_q;
    logic       wr_en;
    assign wr_en = byte_take & (slot == CNT_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     byte_q <= '0;
      else if (wr_en) byte_q <= in_byte;
    end
    assign addr_flat[8*(NBYTES-i)-1 -: 8] = byte_q;
  end

  assign done = done_q;

  // R1: while collecting, the stored count stays between 1 and the last index
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q != '0 && cnt_q <= LAST_IDX));

  // R2: a decision strobe never lasts two cycles
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R2: collection has closed by the time the strobe shows
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !active_q);

  // R3: a stray byte outside an address leaves the collector idle
  p_stray_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && in_valid && !in_first) |=> !active_q && !done_q);

endmodule

// File: rtl/rxaf_crc.sv
module rxaf_crc
  import rxaf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              restart,
  input  logic [7:0]        data,
  output logic [HASH_W-1:0] hash_idx
);

  logic [CRC_W-1:0] crc_q, crc_d, crc_base;

  assign crc_base = restart ? '1 : crc_q;

  always_comb begin
    crc_d = crc_q;
    if (step_en) crc_d = crc_step_byte(crc_base, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_d;
  end

  assign hash_idx = crc_q[CRC_W-1 -: HASH_W];

  // R7: a restarted address always seeds the CRC afresh
  p_seed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && restart) |=> (crc_q == crc_step_byte('1, $past(data))));

  // R7: without a byte the CRC holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(crc_q));

endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
  import rxaf_pkg::*;
#(
  parameter int unsigned NBYTES = ADDR_BYTES,
  parameter int unsigned HW     = HASH_W,
  parameter int unsigned WORD_W = TBL_WORD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  eval,
  input  logic [8*NBYTES-1:0]   addr,
  input  logic [HW-1:0]         hash_idx,
  input  rxaf_cfg_t             cfg,
  input  logic [8*NBYTES-1:0]   station,
  input  logic [2*WORD_W-1:0]   table_bits,
  output logic                  accept
);

  localparam int unsigned SEL_W   = $clog2(WORD_W);
  localparam int unsigned N_WORDS = (1 << HW) / WORD_W;

  rxaf_class_e    cls;
  logic           station_hit;
  logic           bin_set;
  logic [WORD_W-1:0] word_pick;
  logic [WORD_W-1:0] words [N_WORDS];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign words[w] = table_bits[w*WORD_W +: WORD_W];
  end

  if (N_WORDS > 1) begin : g_multi
    assign word_pick = words[hash_idx[HW-1:SEL_W]];
  end else begin : g_single
    assign word_pick = words[0];
  end

  assign bin_set     = word_pick[hash_idx[SEL_W-1:0]];
  assign station_hit = (addr == station);

  always_comb begin
    if (&addr)                   cls = CLS_BROADCAST;
    else if (addr[8*NBYTES-8])   cls = CLS_MULTICAST;
    else                         cls = CLS_UNICAST;
  end

  always_comb begin
    accept = 1'b0;
    if (cfg.promisc || !cfg.addr_filter) begin
      accept = 1'b1;
    end else begin
      unique case (cls)
        CLS_BROADCAST: accept = cfg.bcast_accept;
        CLS_MULTICAST: accept = cfg.mcast_accept & (~cfg.hash_enable | bin_set);
        CLS_UNICAST:   accept = cfg.ucast_check & station_hit;
        default:       accept = 1'b0;
      endcase
    end
  end

  // R6: broadcast is dropped when its enable is off and filtering applies
  p_bcast_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !cfg.promisc && cfg.addr_filter && (&addr) && !cfg.bcast_accept) |-> !accept);

  // R8: multicast is dropped when its enable is off
  p_mcast_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !cfg.promisc && cfg.addr_filter && cls == CLS_MULTICAST && !cfg.mcast_accept)
      |-> !accept);

endmodule

// File: rtl/rxaf_filter.sv
module rxaf_filter
  import rxaf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        da_valid,
  input  logic        da_first,
  input  logic [7:0]  da_byte,
  input  logic        cfg_promisc,
  input  logic        cfg_addr_filter,
  input  logic        cfg_ucast_check,
  input  logic        cfg_mcast_accept,
  input  logic        cfg_bcast_accept,
  input  logic        cfg_hash_enable,
  input  logic [23:0] station_hi,
  input  logic [23:0] station_lo,
  input  logic [31:0] hash_tbl_lo,
  input  logic [31:0] hash_tbl_hi,
  output logic        dec_valid,
  output logic        dec_accept
);

  logic              take, restart, done;
  logic [ADDR_W-1:0] addr;
  logic [HASH_W-1:0] idx;
  logic              raw_accept;
  rxaf_cfg_t         cfg;

  assign cfg = '{promisc:      cfg_promisc,
                 addr_filter:  cfg_addr_filter,
                 ucast_check:  cfg_ucast_check,
                 mcast_accept: cfg_mcast_accept,
                 bcast_accept: cfg_bcast_accept,
                 hash_enable:  cfg_hash_enable};

  rxaf_capture #(.NBYTES(ADDR_BYTES)) capture_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (da_valid),
    .in_first     (da_first),
    .in_byte      (da_byte),
    .byte_take    (take),
    .byte_restart (restart),
    .addr_flat    (addr),
    .done         (done)
  );

  rxaf_crc crc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (take),
    .restart  (restart),
    .data     (da_byte),
    .hash_idx (idx)
  );

  rxaf_decide #(.NBYTES(ADDR_BYTES), .HW(HASH_W), .WORD_W(TBL_WORD_W)) decide_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval       (done),
    .addr       (addr),
    .hash_idx   (idx),
    .cfg        (cfg),
    .station    ({station_hi, station_lo}),
    .table_bits ({hash_tbl_hi, hash_tbl_lo}),
    .accept     (raw_accept)
  );

  assign dec_valid  = done;
  assign dec_accept = done & raw_accept;

  // R2: no accept without a strobe
  p_accept_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept);

  // R4: promiscuous mode never rejects
  p_promisc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && cfg_promisc) |-> dec_accept);

  // R5: filtering off never rejects
  p_nofilter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !cfg_addr_filter) |-> dec_accept);

  // R9: an accepted unicast frame under filtering matched the station
  p_ucast_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_accept && !cfg_promisc && cfg_addr_filter && !addr[ADDR_W-8])
      |-> (addr == {station_hi, station_lo}));

endmodule

// File: tb/rxaf_filter_tb.sv
module rxaf_filter_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        da_valid, da_first;
  logic [7:0]  da_byte;
  logic        cfg_promisc, cfg_addr_filter, cfg_ucast_check;
  logic        cfg_mcast_accept, cfg_bcast_accept, cfg_hash_enable;
  logic [23:0] station_hi, station_lo;
  logic [31:0] hash_tbl_lo, hash_tbl_hi;
  logic        dec_valid, dec_accept;

  int checks = 0;
  int failures = 0;

  localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
  localparam logic [47:0] OTHER   = 48'h02_11_22_33_44_56;
  localparam logic [47:0] BCAST   = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MC_A    = 48'h01_00_5E_00_00_FB;
  localparam logic [47:0] MC_B    = 48'h33_33_00_00_00_01;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxaf_filter dut_i (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_first(da_first), .da_byte(da_byte),
    .cfg_promisc(cfg_promisc), .cfg_addr_filter(cfg_addr_filter),
    .cfg_ucast_check(cfg_ucast_check), .cfg_mcast_accept(cfg_mcast_accept),
    .cfg_bcast_accept(cfg_bcast_accept), .cfg_hash_enable(cfg_hash_enable),
    .station_hi(station_hi), .station_lo(station_lo),
    .hash_tbl_lo(hash_tbl_lo), .hash_tbl_hi(hash_tbl_hi),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  function automatic logic [5:0] exp_bin(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [7:0]  b;
    logic        fb;
    for (int i = 0; i < 6; i++) begin
      b = a[47-8*i -: 8];
      for (int k = 0; k < 8; k++) begin
        fb = c[31] ^ b[k];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    end
    return c[31:26];
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic set_defaults();
    cfg_promisc = 1'b0; cfg_addr_filter = 1'b1; cfg_ucast_check = 1'b1;
    cfg_mcast_accept = 1'b1; cfg_bcast_accept = 1'b1; cfg_hash_enable = 1'b1;
    station_hi = STATION[47:24]; station_lo = STATION[23:0];
    hash_tbl_lo = '0; hash_tbl_hi = '0;
  endtask

  task automatic load_table(input logic [47:0] a, input bit hit);
    logic [63:0] t = 64'd1 << exp_bin(a);
    if (!hit) t = ~t;
    hash_tbl_lo = t[31:0];
    hash_tbl_hi = t[63:32];
  endtask

  // Drives an address, optionally with a bubble before byte 3, then checks
  // the strobe in the cycle after byte 5 and its drop one cycle later.
  task automatic frame(input string req, input logic [47:0] a, input bit bubble, input bit exp_acc);
    for (int i = 0; i < 6; i++) begin
      if (bubble && i == 3) begin
        @(negedge clk); da_valid = 1'b0; da_first = 1'b0;
      end
      @(negedge clk);
      da_valid = 1'b1; da_first = (i == 0); da_byte = a[47-8*i -: 8];
      check({req, " no early strobe"}, 64'(dec_valid), 64'd0);
    end
    @(negedge clk);
    da_valid = 1'b0; da_first = 1'b0;
    check({req, " strobe"}, 64'(dec_valid), 64'd1);
    check({req, " accept"}, 64'(dec_accept), 64'(exp_acc));
    @(negedge clk);
    check({req, " strobe drop R2"}, 64'(dec_valid), 64'd0);
    check({req, " accept low R2"}, 64'(dec_accept), 64'd0);
  endtask

  task automatic t_reset();
    check("R10 valid after reset", 64'(dec_valid), 64'd0);
    check("R10 accept after reset", 64'(dec_accept), 64'd0);
  endtask

  task automatic t_unicast();
    set_defaults();
    frame("R9 R1 station match", STATION, 1'b0, 1'b1);
    frame("R9 mismatch", OTHER, 1'b0, 1'b0);
    frame("R1 bubble match", STATION, 1'b1, 1'b1);
    cfg_ucast_check = 1'b0;
    frame("R9 check off", STATION, 1'b0, 1'b0);
  endtask

  task automatic t_promisc_nofilter();
    set_defaults();
    cfg_promisc = 1'b1; cfg_mcast_accept = 1'b0; cfg_bcast_accept = 1'b0;
    frame("R4 promisc unicast", OTHER, 1'b0, 1'b1);
    frame("R4 promisc multicast", MC_A, 1'b0, 1'b1);
    cfg_promisc = 1'b0; cfg_addr_filter = 1'b0;
    frame("R5 no filter unicast", OTHER, 1'b0, 1'b1);
    frame("R5 no filter broadcast", BCAST, 1'b0, 1'b1);
  endtask

  task automatic t_broadcast();
    set_defaults();
    frame("R6 broadcast on", BCAST, 1'b0, 1'b1);
    cfg_bcast_accept = 1'b0;
    frame("R6 broadcast off", BCAST, 1'b0, 1'b0);
  endtask

  task automatic t_hash();
    set_defaults();
    load_table(MC_A, 1'b1);
    frame("R7 hash hit A", MC_A, 1'b0, 1'b1);
    load_table(MC_A, 1'b0);
    frame("R7 hash miss A", MC_A, 1'b0, 1'b0);
    load_table(MC_B, 1'b1);
    frame("R7 hash hit B", MC_B, 1'b1, 1'b1);
    load_table(MC_B, 1'b0);
    frame("R7 hash miss B", MC_B, 1'b0, 1'b0);
  endtask

  task automatic t_mcast_policy();
    set_defaults();
    cfg_hash_enable = 1'b0;
    frame("R8 hash off accepts", MC_A, 1'b0, 1'b1);
    cfg_mcast_accept = 1'b0;
    hash_tbl_lo = '1; hash_tbl_hi = '1;
    cfg_hash_enable = 1'b1;
    frame("R8 multicast off", MC_A, 1'b0, 1'b0);
  endtask

  task automatic t_restart_stray();
    set_defaults();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      da_valid = 1'b1; da_first = (i == 0); da_byte = OTHER[47-8*i -: 8];
    end
    frame("R3 restart", STATION, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      da_valid = 1'b1; da_first = 1'b0; da_byte = STATION[47-8*i -: 8];
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      da_valid = 1'b0;
      check("R3 stray bytes no strobe", 64'(dec_valid), 64'd0);
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cyc++;
    end
    failures++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG_CYCLES);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; da_valid = 1'b0; da_first = 1'b0; da_byte = '0;
    set_defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unicast();
    t_promisc_nofilter();
    t_broadcast();
    t_hash();
    t_mcast_policy();
    t_restart_stray();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule